// File: doc/BRIEF.md
# Configurable GPIO Cell Bank

This block runs a small bank of general-purpose digital pins from a single control register. The register gives every pin two bits: an output setting and a pull-up disable. A setting of 0 enables the pad driver, which then pulls the pad low. A setting of 1 turns the driver off, so the pad level is decided by the modelled pull-up or by whatever is connected outside. A pull-up disable bit of 0 turns the pin's pull-up on.

A second register is read-only and reports the level of each pin. For a driven pin it reports the setting bit. For a released pin it reports the sensed pad level, after that level has passed through a two-flop synchronizer. A recall input loads the control register in one cycle from an externally supplied value, for example a stored configuration. Reset loads the default value, which enables every pull-up and releases every output.

Top module: `gpio_cell_bank`

## Requirements
- R1: After reset the control register reads 0x0F, every `pad_oe` bit is 0 and every `pad_pu_en` bit is 1.
- R2: A write to address 0 stores `wr_data` in the control register. From the next cycle, a pin whose setting bit (bit i, for i = 0..3) is 0 has `pad_oe[i]`=1 and `pad_out[i]`=0, and a pin whose setting bit is 1 has `pad_oe[i]`=0.
- R3: Control bit 4+i is the pull-up disable for pin i. When it is 0, `pad_pu_en[i]`=1. When it is 1, `pad_pu_en[i]`=0.
- R4: A read of address 1 returns the state register. For a pin whose setting bit is 0, state bit i reads 0, whatever level is applied outside.
- R5: For a released pin, state bit i reports the sensed pad level. That level is 1 when the pull-up is enabled and nothing outside drives the pad. Otherwise it is the value driven from outside.
- R6: Bits 7..4 of the state register always read 0.
- R7: When `recall` is high at a clock edge, the control register takes `recall_val` at that edge. A write in the same cycle is discarded.
- R8: Writes to address 1 have no effect, and the control register reads back unchanged afterwards.
- R9: Reads of addresses 2 and 3 return 0.
- R10: A change in the pad level of a released pin appears in the state register after two clock edges and not after one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recall | input | 1 | Load the control register from `recall_val` |
| recall_val | input | 8 | Value to load on recall |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 = control, 1 = state) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data for `rd_addr`, combinational |
| pad_out | output | 4 | Pad output value (always 0 when driving) |
| pad_oe | output | 4 | Pad driver enable per pin |
| pad_pu_en | output | 4 | Pull-up enable per pin |
| pad_in | input | 4 | Sensed pad level per pin |

## Verification
The main check writes one control pattern that gives each of the four pins a different pull-up/setting combination. It then applies three external conditions to all pins together: driven high, driven low and released. The driven-high case shows that a driving pin ignores its pad and reports its setting. The driven-low case shows that an external level overrides the pull-up. The released case shows that the pull-up alone produces a high reading. A separate step-response test on one pin tells apart a synchronizer of the required depth from one that is too short or missing. Writes that coincide with recall and writes to the read-only address check that the control register is updated only by the correct source.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   // Electrical situation of one pin, derived from its two control bits.
   typedef enum logic [1:0] {
      PIN_DRIVE_LOW   = 2'd0,
      PIN_PULLED_HIGH = 2'd1,
      PIN_FLOATING    = 2'd2
   } pin_mode_e;

   function automatic pin_mode_e decode_mode(input logic set_bit, input logic pu_dis);
      if (!set_bit)    return PIN_DRIVE_LOW;
      else if (!pu_dis) return PIN_PULLED_HIGH;
      else              return PIN_FLOATING;
   endfunction

endpackage

// File: rtl/gpio_ctrl_reg.sv
module gpio_ctrl_reg #(
   parameter int unsigned             WIDTH     = 8,
   parameter logic [WIDTH-1:0]        RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             recall,
   input  logic [WIDTH-1:0] recall_val,
   input  logic             wr_hit,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] q
);

   // Recall has priority over a register write in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= RESET_VAL;
      else if (recall) q <= recall_val;
      else if (wr_hit) q <= wr_data;
   end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)      stage_q[s] <= '0;
               else if (s == 0) stage_q[s] <= d;
               else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
         end
         assign q = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/gpio_pad_cell.sv
module gpio_pad_cell
   import gpio_bank_pkg::*;
(
   input  logic set_bit,
   input  logic pu_dis,
   input  logic sensed,
   output logic pad_out,
   output logic pad_oe,
   output logic pad_pu_en,
   output logic state_bit
);

   pin_mode_e mode;

   always_comb begin
      mode      = decode_mode(set_bit, pu_dis);
      pad_out   = 1'b0;
      pad_oe    = (mode == PIN_DRIVE_LOW);
      pad_pu_en = !pu_dis;
      // A driven pin reports its own setting; a released one reports the pad.
      state_bit = (mode == PIN_DRIVE_LOW) ? set_bit : sensed;
   end

endmodule

// File: rtl/gpio_cell_bank.sv
module gpio_cell_bank #(
   parameter int unsigned        NUM_PINS    = 4,
   parameter int unsigned        DATA_W      = 8,
   parameter int unsigned        ADDR_W      = 2,
   parameter int unsigned        CTRL_ADDR   = 0,
   parameter int unsigned        STATE_ADDR  = 1,
   parameter int unsigned        SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0]  RESET_CTRL  = 8'h0F
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                recall,
   input  logic [DATA_W-1:0]   recall_val,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [DATA_W-1:0]   rd_data,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pad_pu_en,
   input  logic [NUM_PINS-1:0] pad_in
);

   localparam int unsigned       CTRL_W  = 2 * NUM_PINS;
   localparam logic [ADDR_W-1:0] CTRL_A  = CTRL_ADDR[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] STATE_A = STATE_ADDR[ADDR_W-1:0];

   generate
      if (NUM_PINS < 1)        begin : g_bad_pins  $error("NUM_PINS must be at least 1"); end
      if (CTRL_W > DATA_W)     begin : g_bad_width $error("DATA_W too narrow for 2*NUM_PINS"); end
      if (CTRL_ADDR == STATE_ADDR) begin : g_bad_map $error("register addresses collide"); end
      if (CTRL_ADDR >= (1 << ADDR_W) || STATE_ADDR >= (1 << ADDR_W))
                                begin : g_bad_addr  $error("address outside ADDR_W"); end
   endgenerate

   logic [CTRL_W-1:0]   ctrl_q;
   logic [NUM_PINS-1:0] sensed;
   logic [NUM_PINS-1:0] state_bits;
   logic                wr_hit;

   assign wr_hit = wr_en && (wr_addr == CTRL_A);

   gpio_ctrl_reg #(
      .WIDTH     (CTRL_W),
      .RESET_VAL (RESET_CTRL[CTRL_W-1:0])
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .recall     (recall),
      .recall_val (recall_val[CTRL_W-1:0]),
      .wr_hit     (wr_hit),
      .wr_data    (wr_data[CTRL_W-1:0]),
      .q          (ctrl_q)
   );

   gpio_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (sensed)
   );

   generate
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
         gpio_pad_cell u_cell (
            .set_bit   (ctrl_q[i]),
            .pu_dis    (ctrl_q[NUM_PINS + i]),
            .sensed    (sensed[i]),
            .pad_out   (pad_out[i]),
            .pad_oe    (pad_oe[i]),
            .pad_pu_en (pad_pu_en[i]),
            .state_bit (state_bits[i])
         );
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      if (rd_addr == CTRL_A)       rd_data[CTRL_W-1:0]   = ctrl_q;
      else if (rd_addr == STATE_A) rd_data[NUM_PINS-1:0] = state_bits;
   end

endmodule

// File: rtl/gpio_cell_bank_chk.sv
module gpio_cell_bank_chk #(
   parameter int unsigned NUM_PINS   = 4,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ADDR_W     = 2,
   parameter int unsigned CTRL_ADDR  = 0,
   parameter int unsigned STATE_ADDR = 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                recall,
   input logic [DATA_W-1:0]   recall_val,
   input logic                wr_en,
   input logic [ADDR_W-1:0]   wr_addr,
   input logic [DATA_W-1:0]   wr_data,
   input logic [ADDR_W-1:0]   rd_addr,
   input logic [DATA_W-1:0]   rd_data,
   input logic [NUM_PINS-1:0] pad_out,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic [NUM_PINS-1:0] pad_pu_en
);

   localparam logic [ADDR_W-1:0] CTRL_A  = CTRL_ADDR[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] STATE_A = STATE_ADDR[ADDR_W-1:0];

   p_write_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == CTRL_A && !recall) |=> (pad_oe == ~$past(wr_data[NUM_PINS-1:0])));

   p_write_pullup_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == CTRL_A && !recall) |=> (pad_pu_en == ~$past(wr_data[2*NUM_PINS-1:NUM_PINS])));

   p_out_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_out & pad_oe) == '0));

   p_driven_reads_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == STATE_A) |-> ((rd_data[NUM_PINS-1:0] & pad_oe) == '0));

   p_state_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == STATE_A) |-> (rd_data[DATA_W-1:NUM_PINS] == '0));

   p_recall_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      recall |=> (pad_oe == ~$past(recall_val[NUM_PINS-1:0])));

   p_state_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == STATE_A && !recall) |=> ($stable(pad_oe) && $stable(pad_pu_en)));

endmodule

bind gpio_cell_bank gpio_cell_bank_chk #(
   .NUM_PINS   (NUM_PINS),
   .DATA_W     (DATA_W),
   .ADDR_W     (ADDR_W),
   .CTRL_ADDR  (CTRL_ADDR),
   .STATE_ADDR (STATE_ADDR)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .recall     (recall),
   .recall_val (recall_val),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .rd_addr    (rd_addr),
   .rd_data    (rd_data),
   .pad_out    (pad_out),
   .pad_oe     (pad_oe),
   .pad_pu_en  (pad_pu_en)
);

// File: tb/gpio_cell_bank_bench.sv
module gpio_cell_bank_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       recall = 1'b0;
   logic [7:0] recall_val = '0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic [3:0] pad_out, pad_oe, pad_pu_en;
   wire  [3:0] pad_lvl;
   logic [3:0] ext_en = '0;
   logic [3:0] ext_val = '0;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   // Resolved pad: the cell's driver wins, then an external driver, then the
   // pull-up; an undriven pad without pull-up settles low in this model.
   for (genvar i = 0; i < 4; i++) begin : g_pad
      assign pad_lvl[i] = pad_oe[i] ? pad_out[i] :
                          ext_en[i] ? ext_val[i] :
                          pad_pu_en[i] ? 1'b1 : 1'b0;
   end

   gpio_cell_bank u_gpio_cell_bank (
      .clk(clk), .rst_n(rst_n), .recall(recall), .recall_val(recall_val),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu_en(pad_pu_en), .pad_in(pad_lvl)
   );

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
      rd_addr = a;
      #0.5;
      d = rd_data;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      reg_read(2'd0, v);
      check("R1 ctrl reset", v, 8'h0F);
      check("R1 oe reset", {4'h0, pad_oe}, 8'h00);
      check("R1 pullup reset", {4'h0, pad_pu_en}, 8'h0F);
      cycles(3);
      reg_read(2'd1, v);
      check("R5 pulled-up idle pins", v, 8'h0F);
   endtask

   task automatic t_drive_and_pullup();
      logic [7:0] v;
      reg_write(2'd0, 8'h5A);
      check("R2 oe from settings", {4'h0, pad_oe}, 8'h05);
      check("R2 out low", {4'h0, pad_out & pad_oe}, 8'h00);
      check("R3 pullup from ctrl", {4'h0, pad_pu_en}, 8'h0A);
      reg_read(2'd0, v);
      check("R2 ctrl readback", v, 8'h5A);
   endtask

   task automatic t_combos();
      logic [7:0] v;
      // pin0 pu on/set0, pin1 pu on/set1, pin2 pu off/set0, pin3 pu off/set1
      reg_write(2'd0, 8'hCA);
      ext_en = 4'hF; ext_val = 4'hF;
      cycles(3);
      reg_read(2'd1, v);
      check("R4 R5 R6 ext high", v, 8'h0A);
      ext_val = 4'h0;
      cycles(3);
      reg_read(2'd1, v);
      check("R5 ext low overrides pullup", v, 8'h00);
      ext_en = 4'h0;
      cycles(3);
      reg_read(2'd1, v);
      check("R5 pullup alone", v & 8'h07, 8'h02);
   endtask

   task automatic t_sync_latency();
      logic [7:0] v;
      reg_write(2'd0, 8'h11);
      ext_en = 4'h1; ext_val = 4'h0;
      cycles(3);
      reg_read(2'd1, v);
      check("R10 settled low", v & 8'h01, 8'h00);
      @(negedge clk);
      ext_val = 4'h1;
      @(negedge clk);
      reg_read(2'd1, v);
      check("R10 one edge not yet", v & 8'h01, 8'h00);
      @(negedge clk);
      reg_read(2'd1, v);
      check("R10 two edges seen", v & 8'h01, 8'h01);
      ext_en = 4'h0;
   endtask

   task automatic t_recall();
      logic [7:0] v;
      @(negedge clk);
      recall = 1'b1; recall_val = 8'h93;
      wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h66;
      @(negedge clk);
      recall = 1'b0; wr_en = 1'b0;
      reg_read(2'd0, v);
      check("R7 recall beats write", v, 8'h93);
      check("R7 oe after recall", {4'h0, pad_oe}, 8'h0C);
   endtask

   task automatic t_state_write();
      logic [7:0] v;
      reg_write(2'd0, 8'h3C);
      reg_write(2'd1, 8'hFF);
      reg_read(2'd0, v);
      check("R8 ctrl unchanged", v, 8'h3C);
      check("R8 pullup unchanged", {4'h0, pad_pu_en}, 8'h0C);
   endtask

   task automatic t_unmapped();
      logic [7:0] v;
      reg_read(2'd2, v);
      check("R9 addr 2", v, 8'h00);
      reg_read(2'd3, v);
      check("R9 addr 3", v, 8'h00);
   endtask

   initial begin
      cycles(3);
      rst_n = 1'b1;
      cycles(1);
      t_reset();
      t_drive_and_pullup();
      t_combos();
      t_sync_latency();
      t_recall();
      t_state_write();
      t_unmapped();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #40000;
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule